// File: doc/BRIEF.md
# Priority Transmit FIFO Filler

This block collects outgoing packets from two descriptor queues, one high priority and one low, and copies their data into a single shared transmit FIFO. It then presents the FIFO contents to the transmit MAC as a word stream. Each descriptor gives a start word address and a length in bytes, and the length must be at least one byte. The block fetches the packet through a simple DMA read port, one burst at a time. Each burst is limited by a programmable size code and by the room left in the FIFO.

Arbitration between the two queues happens only at packet boundaries. A pending high-priority descriptor always wins over a pending low-priority one. A packet that is already being fetched is always completed first. Each FIFO entry carries an end-of-packet flag and the number of valid bytes in the word. The FIFO can hold several complete packets, so the MAC side can take frames back to back without a gap. The default depth of 896 32-bit words gives 3.5 KB of storage.

Top module: `prio_tx_fill`

## Requirements
- R1: While reset is held, and in the first cycle after it, dma_req and mac_valid are low. A descriptor ready is never high while its valid is low.
- R2: When both queues present a descriptor at a packet boundary, the high descriptor is accepted (hi_desc_ready high, lo_desc_ready low) and its data is fetched and delivered first.
- R3: A descriptor arriving while a packet is being fetched is not accepted until the final word of that packet has been received. Packets are delivered in acceptance order.
- R4: Each DMA request length, in words, is the smallest of three values: the remaining words of the packet, the FIFO depth, and the size code's limit. For burst_code values 0 to 6 that limit is 4 << burst_code words (16 to 1024 bytes). Code 7 imposes no limit of its own.
- R5: The first request of a packet uses the descriptor's word address. Each later request continues at the word after the previous burst.
- R6: A request is raised only when the FIFO storage has at least dma_len free entries. The FIFO never overflows. A stalled MAC therefore stops further fills once the space runs short.
- R7: Words appear on mac_data unchanged and in the order in which they were read.
- R8: mac_last is high exactly on the final word of each packet. mac_bytes is 4 on every other word. On the final word it is the byte length mod 4, or 4 when that remainder is 0.
- R9: Once several whole packets sit in the FIFO, a MAC holding mac_ready high receives all of their words on consecutive cycles, with no gap at the packet boundary.
- R10: While mac_valid is high and mac_ready is low, mac_valid stays high and mac_data stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_desc_valid | input | 1 | High-priority descriptor present |
| hi_desc_ready | output | 1 | High-priority descriptor taken this cycle |
| hi_desc_addr | input | AW | High-priority packet start word address |
| hi_desc_len | input | LENW | High-priority packet length in bytes (at least 1) |
| lo_desc_valid | input | 1 | Low-priority descriptor present |
| lo_desc_ready | output | 1 | Low-priority descriptor taken this cycle |
| lo_desc_addr | input | AW | Low-priority packet start word address |
| lo_desc_len | input | LENW | Low-priority packet length in bytes (at least 1) |
| burst_code | input | 3 | Maximum burst size code |
| dma_req | output | 1 | Read burst request, held until granted |
| dma_gnt | input | 1 | Request accepted; dma_len words follow |
| dma_addr | output | AW | Burst start word address |
| dma_len | output | $clog2(DEPTH+1) | Burst length in words |
| dma_rvalid | input | 1 | Read data word valid |
| dma_rdata | input | 32 | Read data word |
| mac_valid | output | 1 | Stream word valid |
| mac_ready | input | 1 | MAC takes the word |
| mac_data | output | 32 | Stream word |
| mac_last | output | 1 | Final word of a packet |
| mac_bytes | output | 3 | Valid bytes in this word (1 to 4) |

## Verification
The hardest situation to reach is the space gate. The fetch side must hold off a burst because the FIFO storage has too little room for it, and resume once the MAC drains enough. The bench builds the block with a small depth, holds mac_ready low during a long packet, and confirms that exactly one burst lands before fills stop. A second hard case is a high-priority descriptor that shows up just after a low packet has been accepted. The bench raises it in the cycle right after the low handshake, expects it to be refused, and checks both the DMA address order and the stream order.

// File: rtl/prio_tx_pkg.sv
package prio_tx_pkg;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic              last;
    logic [2:0]        nbytes;
    logic [WORD_W-1:0] data;
  } fifo_word_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_XFER = 2'd2
  } fetch_state_t;

  // words allowed by a burst code; 0 means the code sets no limit
  function automatic int code_words(input logic [2:0] code);
    if (code == 3'd7) return 0;
    return 4 << code;
  endfunction
endpackage

// File: rtl/prio_tx_fifo.sv
module prio_tx_fifo
  import prio_tx_pkg::*;
#(
  parameter int DEPTH = 896,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  fifo_word_t    wr_word,
  output logic [CW-1:0] free_cnt,
  output logic          out_valid,
  output fifo_word_t    out_word,
  input  logic          out_ready
);
  localparam int EW = $bits(fifo_word_t);

  logic [EW-1:0] store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] used;
  logic          rd_en;

  assign rd_en    = (used != '0) && (!out_valid || out_ready);
  assign free_cnt = CW'(DEPTH) - used;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rd_en) out_word <= store[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      used      <= '0;
      out_valid <= 1'b0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      used <= used + CW'(wr_en) - CW'(rd_en);
      if (rd_en) out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (used < CW'(DEPTH)))
    else $error("fifo written while full");

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)))
    else $error("stream word changed while stalled");
endmodule

// File: rtl/prio_tx_fetch.sv
module prio_tx_fetch
  import prio_tx_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LENW  = 16,
  parameter int DEPTH = 896,
  localparam int WCW = LENW - 1,
  localparam int BW  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hi_valid,
  output logic              hi_ready,
  input  logic [AW-1:0]     hi_addr,
  input  logic [LENW-1:0]   hi_len,
  input  logic              lo_valid,
  output logic              lo_ready,
  input  logic [AW-1:0]     lo_addr,
  input  logic [LENW-1:0]   lo_len,
  input  logic [2:0]        burst_code,
  input  logic [BW-1:0]     free_cnt,
  output logic              dma_req,
  input  logic              dma_gnt,
  output logic [AW-1:0]     dma_addr,
  output logic [BW-1:0]     dma_len,
  input  logic              dma_rvalid,
  input  logic [WORD_W-1:0] dma_rdata,
  output logic              wr_en,
  output fifo_word_t        wr_word
);
  fetch_state_t     state;
  logic [AW-1:0]    cur_addr;
  logic [WCW-1:0]   words_left;
  logic [2:0]       tail_bytes;
  logic [BW-1:0]    burst_left;
  logic             cur_hi;

  logic             take_hi, take_lo;
  logic [LENW-1:0]  sel_len;
  logic [AW-1:0]    sel_addr;
  logic [WCW-1:0]   sel_words;
  logic [2:0]       sel_tail;
  int               cap_words;
  int               want_words;
  logic [BW-1:0]    burst_n;

  always_comb begin
    take_hi   = (state == S_IDLE) && hi_valid;
    take_lo   = (state == S_IDLE) && !hi_valid && lo_valid;
    sel_len   = take_hi ? hi_len : lo_len;
    sel_addr  = take_hi ? hi_addr : lo_addr;
    sel_words = WCW'(({1'b0, sel_len} + (LENW + 1)'(3)) >> 2);
    sel_tail  = (sel_len[1:0] == 2'd0) ? 3'd4 : {1'b0, sel_len[1:0]};

    cap_words = code_words(burst_code);
    if (cap_words == 0 || cap_words > DEPTH) cap_words = DEPTH;
    want_words = 32'(words_left);
    burst_n = (want_words < cap_words) ? BW'(want_words) : BW'(cap_words);

    wr_en          = (state == S_XFER) && dma_rvalid;
    wr_word.data   = dma_rdata;
    wr_word.last   = (words_left == WCW'(1));
    wr_word.nbytes = wr_word.last ? tail_bytes : 3'd4;
  end

  assign hi_ready = take_hi;
  assign lo_ready = take_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      dma_req    <= 1'b0;
      dma_addr   <= '0;
      dma_len    <= '0;
      cur_addr   <= '0;
      words_left <= '0;
      tail_bytes <= 3'd4;
      burst_left <= '0;
      cur_hi     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (take_hi || take_lo) begin
            cur_addr   <= sel_addr;
            words_left <= sel_words;
            tail_bytes <= sel_tail;
            cur_hi     <= take_hi;
            state      <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (dma_req) begin
            if (dma_gnt) begin
              dma_req <= 1'b0;
              state   <= S_XFER;
            end
          end else if (free_cnt >= burst_n) begin
            dma_req    <= 1'b1;
            dma_addr   <= cur_addr;
            dma_len    <= burst_n;
            burst_left <= burst_n;
          end
        end
        S_XFER: begin
          if (dma_rvalid) begin
            words_left <= words_left - 1'b1;
            burst_left <= burst_left - 1'b1;
            cur_addr   <= cur_addr + 1'b1;
            if (burst_left == BW'(1))
              state <= (words_left == WCW'(1)) ? S_IDLE : S_WAIT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_hi_first_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && hi_valid && lo_valid) |=> cur_hi)
    else $error("low packet started while a high one waited");

  assert_burst_cap_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_req) |-> (dma_len != '0 && dma_len <= BW'(cap_words)))
    else $error("burst length outside the allowed range");

  assert_room_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_req) |-> (free_cnt >= dma_len))
    else $error("burst requested without room");
endmodule

// File: rtl/prio_tx_fill.sv
module prio_tx_fill
  import prio_tx_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LENW  = 16,
  parameter int DEPTH = 896,
  localparam int BW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hi_desc_valid,
  output logic              hi_desc_ready,
  input  logic [AW-1:0]     hi_desc_addr,
  input  logic [LENW-1:0]   hi_desc_len,
  input  logic              lo_desc_valid,
  output logic              lo_desc_ready,
  input  logic [AW-1:0]     lo_desc_addr,
  input  logic [LENW-1:0]   lo_desc_len,
  input  logic [2:0]        burst_code,
  output logic              dma_req,
  input  logic              dma_gnt,
  output logic [AW-1:0]     dma_addr,
  output logic [BW-1:0]     dma_len,
  input  logic              dma_rvalid,
  input  logic [WORD_W-1:0] dma_rdata,
  output logic              mac_valid,
  input  logic              mac_ready,
  output logic [WORD_W-1:0] mac_data,
  output logic              mac_last,
  output logic [2:0]        mac_bytes
);
  logic          wr_en;
  fifo_word_t    wr_word;
  fifo_word_t    out_word;
  logic [BW-1:0] free_cnt;

  prio_tx_fetch #(.AW(AW), .LENW(LENW), .DEPTH(DEPTH)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .hi_valid   (hi_desc_valid),
    .hi_ready   (hi_desc_ready),
    .hi_addr    (hi_desc_addr),
    .hi_len     (hi_desc_len),
    .lo_valid   (lo_desc_valid),
    .lo_ready   (lo_desc_ready),
    .lo_addr    (lo_desc_addr),
    .lo_len     (lo_desc_len),
    .burst_code (burst_code),
    .free_cnt   (free_cnt),
    .dma_req    (dma_req),
    .dma_gnt    (dma_gnt),
    .dma_addr   (dma_addr),
    .dma_len    (dma_len),
    .dma_rvalid (dma_rvalid),
    .dma_rdata  (dma_rdata),
    .wr_en      (wr_en),
    .wr_word    (wr_word)
  );

  prio_tx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_word   (wr_word),
    .free_cnt  (free_cnt),
    .out_valid (mac_valid),
    .out_word  (out_word),
    .out_ready (mac_ready)
  );

  assign mac_data  = out_word.data;
  assign mac_last  = out_word.last;
  assign mac_bytes = out_word.nbytes;
endmodule

// File: tb/prio_tx_fill_test.sv
`timescale 1ns/1ps
module prio_tx_fill_test;
  localparam int DEPTH = 24;
  localparam int AW    = 32;
  localparam int LENW  = 16;
  localparam int BW    = $clog2(DEPTH + 1);
  localparam int NVEC  = 7;
  // hi_len, lo_len, burst_code, mac stall mode (0 = always ready, 1 = pattern)
  localparam int VEC [NVEC][4] = '{
    '{13, 9, 0, 0}, '{64, 30, 1, 1}, '{100, 0, 2, 0}, '{0, 160, 7, 1},
    '{7, 6, 3, 0}, '{200, 44, 4, 1}, '{4, 5, 6, 0}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hi_desc_valid = 1'b0, lo_desc_valid = 1'b0;
  logic hi_desc_ready, lo_desc_ready;
  logic [AW-1:0] hi_desc_addr = '0, lo_desc_addr = '0;
  logic [LENW-1:0] hi_desc_len = '0, lo_desc_len = '0;
  logic [2:0] burst_code = 3'd0;
  logic dma_req;
  logic dma_gnt = 1'b0;
  logic [AW-1:0] dma_addr;
  logic [BW-1:0] dma_len;
  logic dma_rvalid = 1'b0;
  logic [31:0] dma_rdata = '0;
  logic mac_valid;
  logic mac_ready = 1'b0;
  logic [31:0] mac_data;
  logic mac_last;
  logic [2:0] mac_bytes;

  always #2.5 clk = ~clk;

  prio_tx_fill #(.AW(AW), .LENW(LENW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst),
    .hi_desc_valid(hi_desc_valid), .hi_desc_ready(hi_desc_ready),
    .hi_desc_addr(hi_desc_addr), .hi_desc_len(hi_desc_len),
    .lo_desc_valid(lo_desc_valid), .lo_desc_ready(lo_desc_ready),
    .lo_desc_addr(lo_desc_addr), .lo_desc_len(lo_desc_len),
    .burst_code(burst_code),
    .dma_req(dma_req), .dma_gnt(dma_gnt), .dma_addr(dma_addr), .dma_len(dma_len),
    .dma_rvalid(dma_rvalid), .dma_rdata(dma_rdata),
    .mac_valid(mac_valid), .mac_ready(mac_ready), .mac_data(mac_data),
    .mac_last(mac_last), .mac_bytes(mac_bytes));

  int nchk = 0, nerr = 0;
  int mode = 0;
  int cyc = 0;
  int pk_addr [64];
  int pk_words [64];
  int pk_n = 0;
  logic [31:0] exp_data [1024];
  logic        exp_last [1024];
  int          exp_bytes [1024];
  int          hs_cyc [1024];
  int exp_n = 0, rx_n = 0;
  int wr = 0, tk = 0;
  int pk_i = 0, rem = 0, ea = 0;
  int rst_st = 0, r_left = 0, r_addr = 0;
  bit prev_stall = 1'b0;
  logic [31:0] prev_data = '0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic [31:0] pat(input int a);
    logic [31:0] av;
    av = a;
    return {av[15:0] ^ 16'hC3A5, av[15:0]};
  endfunction

  function automatic int eff_len(input int code, input int r);
    int c;
    c = (code == 7) ? DEPTH : (4 << code);
    if (c > DEPTH) c = DEPTH;
    return (r < c) ? r : c;
  endfunction

  task automatic add_pkt(input int addr, input int len);
    int nw;
    nw = (len + 3) / 4;
    pk_addr[pk_n] = addr;
    pk_words[pk_n] = nw;
    pk_n++;
    for (int w = 0; w < nw; w++) begin
      exp_data[exp_n]  = pat(addr + w);
      exp_last[exp_n]  = (w == nw - 1);
      exp_bytes[exp_n] = (w == nw - 1) ? ((len % 4 == 0) ? 4 : len % 4) : 4;
      exp_n++;
    end
  endtask

  // DMA responder and MAC monitor, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (rst_st == 0) begin
        if (dma_req) begin
          if (rem == 0) begin
            chk(pk_i < pk_n, "R3 unexpected request", pk_i, pk_n);
            if (pk_i < pk_n) begin
              rem = pk_words[pk_i];
              ea = pk_addr[pk_i];
              pk_i++;
            end
          end
          chk(int'(dma_addr) == ea, "R5 burst address", int'(dma_addr), ea);
          chk(int'(dma_len) == eff_len(int'(burst_code), rem), "R4 burst length",
              int'(dma_len), eff_len(int'(burst_code), rem));
          chk(DEPTH - (wr - tk - int'(mac_valid)) >= int'(dma_len), "R6 room for burst",
              DEPTH - (wr - tk - int'(mac_valid)), int'(dma_len));
          rem = rem - int'(dma_len);
          ea = ea + int'(dma_len);
          r_left = int'(dma_len);
          r_addr = int'(dma_addr);
          dma_gnt = 1'b1;
          rst_st = 1;
        end
      end else begin
        if (rst_st == 1) begin
          dma_gnt = 1'b0;
          rst_st = 2;
        end
        if (r_left > 0) begin
          dma_rvalid = 1'b1;
          dma_rdata = pat(r_addr);
          r_addr++;
          r_left--;
          wr++;
        end else begin
          dma_rvalid = 1'b0;
          rst_st = 0;
        end
      end
      if (prev_stall) begin
        chk(mac_valid == 1'b1, "R10 valid held", int'(mac_valid), 1);
        chk(mac_data == prev_data, "R10 data held", int'(mac_data), int'(prev_data));
      end
      if (mode == 0) mac_ready = 1'b1;
      else if (mode == 1) mac_ready = (cyc % 3 != 0);
      else mac_ready = 1'b0;
      if (mac_valid && mac_ready) begin
        if (rx_n < exp_n) begin
          chk(mac_data == exp_data[rx_n], "R7 data", int'(mac_data), int'(exp_data[rx_n]));
          chk(mac_last == exp_last[rx_n], "R8 last", int'(mac_last), int'(exp_last[rx_n]));
          chk(int'(mac_bytes) == exp_bytes[rx_n], "R8 bytes", int'(mac_bytes), exp_bytes[rx_n]);
        end else begin
          chk(1'b0, "R7 extra word", rx_n, exp_n);
        end
        hs_cyc[rx_n] = cyc;
        rx_n++;
        tk++;
      end
      prev_stall = mac_valid && !mac_ready;
      prev_data = mac_data;
    end
  end

  task automatic pump();
    bit ha, la;
    do begin
      #1;
      ha = hi_desc_valid && hi_desc_ready;
      la = lo_desc_valid && lo_desc_ready;
      @(negedge clk);
      if (ha) hi_desc_valid = 1'b0;
      if (la) lo_desc_valid = 1'b0;
    end while (hi_desc_valid || lo_desc_valid);
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (rx_n < exp_n && t < 4000) begin
      @(negedge clk);
      t++;
    end
    chk(rx_n == exp_n, "R7 word count", rx_n, exp_n);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    int first, w0, t;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(dma_req == 1'b0, "R1 dma_req in reset", int'(dma_req), 0);
    chk(mac_valid == 1'b0, "R1 mac_valid in reset", int'(mac_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(dma_req == 1'b0, "R1 dma_req after reset", int'(dma_req), 0);
    chk(mac_valid == 1'b0, "R1 mac_valid after reset", int'(mac_valid), 0);
    chk(!hi_desc_ready && !lo_desc_ready, "R1 ready without valid",
        int'(hi_desc_ready) + int'(lo_desc_ready), 0);

    // table walk: both queues offered together, high must come first (R2)
    for (int i = 0; i < NVEC; i++) begin
      burst_code = 3'(VEC[i][2]);
      mode = VEC[i][3];
      if (VEC[i][0] != 0) add_pkt(32'h1000 + 256 * i, VEC[i][0]);
      if (VEC[i][1] != 0) add_pkt(32'h8000 + 256 * i, VEC[i][1]);
      @(negedge clk);
      hi_desc_valid = (VEC[i][0] != 0);
      hi_desc_addr = 32'h1000 + 256 * i;
      hi_desc_len = LENW'(VEC[i][0]);
      lo_desc_valid = (VEC[i][1] != 0);
      lo_desc_addr = 32'h8000 + 256 * i;
      lo_desc_len = LENW'(VEC[i][1]);
      if (hi_desc_valid && lo_desc_valid) begin
        #1;
        chk(hi_desc_ready && !lo_desc_ready, "R2 high accepted first",
            int'({hi_desc_ready, lo_desc_ready}), 2);
      end
      pump();
      wait_done();
    end

    // R3: high descriptor arrives right after a low packet starts
    burst_code = 3'd0;
    mode = 0;
    add_pkt(32'h9000, 40);
    add_pkt(32'hA000, 8);
    @(negedge clk);
    lo_desc_valid = 1'b1;
    lo_desc_addr = 32'h9000;
    lo_desc_len = LENW'(40);
    pump();
    hi_desc_valid = 1'b1;
    hi_desc_addr = 32'hA000;
    hi_desc_len = LENW'(8);
    #1;
    chk(!hi_desc_ready, "R3 refused mid packet", int'(hi_desc_ready), 0);
    pump();
    wait_done();

    // R9: two whole packets resident, then drained back to back
    burst_code = 3'd3;
    mode = 2;
    add_pkt(32'hB000, 12);
    add_pkt(32'hB100, 20);
    @(negedge clk);
    hi_desc_valid = 1'b1;
    hi_desc_addr = 32'hB000;
    hi_desc_len = LENW'(12);
    lo_desc_valid = 1'b1;
    lo_desc_addr = 32'hB100;
    lo_desc_len = LENW'(20);
    pump();
    t = 0;
    while (wr < exp_n && t < 500) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    first = rx_n;
    mode = 0;
    wait_done();
    chk(hs_cyc[exp_n - 1] - hs_cyc[first] == exp_n - 1 - first, "R9 back to back",
        hs_cyc[exp_n - 1] - hs_cyc[first], exp_n - 1 - first);

    // R6: stalled MAC, fills stop when a 16-word burst no longer fits
    burst_code = 3'd2;
    mode = 2;
    w0 = wr;
    add_pkt(32'hC000, 300);
    @(negedge clk);
    hi_desc_valid = 1'b1;
    hi_desc_addr = 32'hC000;
    hi_desc_len = LENW'(300);
    pump();
    repeat (200) @(negedge clk);
    chk(wr - w0 == 16, "R6 fill stops when full", wr - w0, 16);
    mode = 0;
    wait_done();

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule